// File: doc/BRIEF.md
# MAC Table Aging Timer

This block ages the learned entries of a small MAC address table. A 16-bit control register carries an 8-bit age multiplier, a learn-to-all enable and four upper database-number bits. A prescaler turns the multiplier into a periodic one-cycle age tick: one tick every `COEFF_CYCLES × age` clock cycles. Each tick launches a background scan that walks the table once through a simple combinational-read, single-write port.

During the walk, every entry holding a dynamic state (1 to 14) is rewritten with its state minus one. Empty entries (state 0) and static entries (state 15) are left alone. When an entry steps from 1 to 0 it becomes free, and the block raises a one-cycle age-out pulse carrying the entry index.

The scanner has two named states. In `SCAN_IDLE` it waits. On a tick it moves to `SCAN_RUN` with index 0. In `SCAN_RUN` it visits one entry per cycle. At the last index it goes back to `SCAN_IDLE`, or it restarts at index 0 if a tick is pending or arrives in that cycle. A tick seen earlier in `SCAN_RUN` sets a one-deep pending flag.

Top module: `mac_age_timer`

## Requirements
- R1: Control register layout: bits 15:12 are the upper database bits (driven on `db_hi`), bits 11:4 are the age multiplier, bit 3 is learn-to-all (driven on `learn_all`), and bits 2:0 are spare storage. The reset value is 0x0010 (age 1). A full write with a non-zero age field stores all 16 bits.
- R2: An age-only write changes bits 11:4 and nothing else.
- R3: An age value of 0 is never stored. An age-only write of 0 is ignored. A full write whose age field is 0 stores bits 15:12 and 3:0 and keeps the previous age.
- R4: `age_tick` is a single-cycle pulse repeating every `COEFF_CYCLES × age` cycles.
- R5: Any write that stores an age value restarts the prescaler. The next tick comes `COEFF_CYCLES × age` cycles after the write cycle.
- R6: The cycle after a tick that finds the scanner idle, `scan_busy` rises and `tbl_addr` visits 0 to N-1 on consecutive cycles. `scan_busy` is high exactly during visits.
- R7: A visited entry in state 1 to 14 is written with state − 1 in its visit cycle. Entries in state 0 or 15 are never written.
- R8: `age_out` pulses in the visit cycle where an entry goes from 1 to 0, with `age_out_idx` equal to that index.
- R9: A tick during a pass is held one deep, and ticks during the same pass merge. The next pass starts with index 0 right after index N-1.
- R10: When a full write and an age-only write occur in the same cycle, the age-only value (if non-zero) sets bits 11:4 and the full write sets the other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Full control-register write strobe |
| ctl_wdata | input | 16 | Full write data |
| age_wr | input | 1 | Age-field-only write strobe |
| age_wdata | input | 8 | Age-only write data |
| ctl_rdata | output | 16 | Control register contents |
| learn_all | output | 1 | Learn-to-all enable (bit 3) |
| db_hi | output | 4 | Upper database-number bits (15:12) |
| age_tick | output | 1 | Aging period pulse |
| scan_busy | output | 1 | Scan pass in progress |
| tbl_addr | output | $clog2(N_ENTRIES) | Table entry index |
| tbl_rdata | input | 4 | State of the addressed entry (same-cycle read) |
| tbl_we | output | 1 | Table write enable |
| tbl_wdata | output | 4 | New entry state |
| age_out | output | 1 | Entry freed by aging |
| age_out_idx | output | $clog2(N_ENTRIES) | Index of the freed entry |

## Verification
A prescaler count off by even one cycle shows up as an `age_tick` in the wrong cycle within one period after the last write or reset. A corrupted scanner index or pending flag shows up within one pass, as a wrong `tbl_addr`, a wrong `scan_busy` edge or a lost pass. A wrong decrement decision shows up in the same cycle on `tbl_we`/`tbl_wdata`, and it leaves table contents that differ from the bench's expected image at the end of each phase.

// File: rtl/age_pkg.sv
package age_pkg;

    localparam int CTL_W      = 16;
    localparam int AGE_W      = 8;
    localparam int AGE_LSB    = 4;
    localparam int AGE_MSB    = AGE_LSB + AGE_W - 1;
    localparam int LEARN_BIT  = 3;
    localparam int DBH_LSB    = 12;
    localparam int STATE_W    = 4;

    localparam logic [STATE_W-1:0] STATE_EMPTY  = 4'h0;
    localparam logic [STATE_W-1:0] STATE_STATIC = 4'hF;
    localparam logic [STATE_W-1:0] STATE_LAST   = 4'h1;

    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_e;

endpackage

// File: rtl/age_ctl_reg.sv
module age_ctl_reg
    import age_pkg::*;
#(
    parameter logic [AGE_W-1:0] AGE_RST = 8'd1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             age_wr,
    input  logic [AGE_W-1:0] age_wdata,
    output logic [CTL_W-1:0] ctl_q,
    output logic [AGE_W-1:0] age_val,
    output logic             restart
);

    localparam logic [CTL_W-1:0] CTL_RST = CTL_W'(AGE_RST) << AGE_LSB;

    logic [CTL_W-1:0] ctl_d;
    logic             full_age_ok;
    logic             short_age_ok;

    assign full_age_ok  = ctl_wr && (ctl_wdata[AGE_MSB:AGE_LSB] != '0);
    assign short_age_ok = age_wr && (age_wdata != '0);

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) begin
            ctl_d[CTL_W-1:AGE_MSB+1] = ctl_wdata[CTL_W-1:AGE_MSB+1];
            ctl_d[AGE_LSB-1:0]       = ctl_wdata[AGE_LSB-1:0];
            if (full_age_ok) begin
                ctl_d[AGE_MSB:AGE_LSB] = ctl_wdata[AGE_MSB:AGE_LSB];
            end
        end
        if (short_age_ok) begin
            ctl_d[AGE_MSB:AGE_LSB] = age_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign age_val = ctl_q[AGE_MSB:AGE_LSB];
    assign restart = full_age_ok || short_age_ok;

endmodule

// File: rtl/age_prescaler.sv
module age_prescaler
    import age_pkg::*;
#(
    parameter int COEFF_CYCLES = 50000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [AGE_W-1:0] age_val,
    output logic             tick
);

    logic             unit_step;
    logic [AGE_W-1:0] unit_q;
    logic             unit_wrap;

    generate
        if (COEFF_CYCLES > 1) begin : g_coeff
            localparam int CW = $clog2(COEFF_CYCLES);
            localparam logic [CW-1:0] C_LAST = CW'(COEFF_CYCLES - 1);
            logic [CW-1:0] coeff_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    coeff_q <= '0;
                end else if (restart || coeff_q == C_LAST) begin
                    coeff_q <= '0;
                end else begin
                    coeff_q <= coeff_q + 1'b1;
                end
            end

            assign unit_step = (coeff_q == C_LAST);
        end else begin : g_unit
            assign unit_step = 1'b1;
        end
    endgenerate

    assign unit_wrap = (unit_q == age_val - 8'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unit_q <= '0;
        end else if (restart) begin
            unit_q <= '0;
        end else if (unit_step) begin
            unit_q <= unit_wrap ? '0 : unit_q + 1'b1;
        end
    end

    assign tick = unit_step && unit_wrap;

endmodule

// File: rtl/age_scanner.sv
module age_scanner
    import age_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int IDX_W     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    output logic [IDX_W-1:0]   tbl_addr,
    input  logic [STATE_W-1:0] tbl_rdata,
    output logic               tbl_we,
    output logic [STATE_W-1:0] tbl_wdata,
    output logic               busy,
    output logic               age_out,
    output logic [IDX_W-1:0]   age_out_idx
);

    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(N_ENTRIES - 1);

    scan_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             pend_q, pend_d;
    logic             at_last;
    logic             dynamic_ent;

    assign at_last = (idx_q == IDX_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SCAN_IDLE;
            idx_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            pend_q  <= pend_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        pend_d  = pend_q;
        unique case (state_q)
            SCAN_IDLE: begin
                if (tick) begin
                    state_d = SCAN_RUN;
                    idx_d   = '0;
                    pend_d  = 1'b0;
                end
            end
            SCAN_RUN: begin
                if (at_last) begin
                    if (tick || pend_q) begin
                        idx_d  = '0;
                        pend_d = 1'b0;
                    end else begin
                        state_d = SCAN_IDLE;
                    end
                end else begin
                    idx_d = idx_q + 1'b1;
                    if (tick) begin
                        pend_d = 1'b1;
                    end
                end
            end
        endcase
    end

    assign dynamic_ent = (tbl_rdata != STATE_EMPTY) && (tbl_rdata != STATE_STATIC);

    // outputs
    always_comb begin
        busy        = 1'b0;
        tbl_we      = 1'b0;
        age_out     = 1'b0;
        tbl_wdata   = tbl_rdata - 4'd1;
        tbl_addr    = idx_q;
        age_out_idx = idx_q;
        unique case (state_q)
            SCAN_IDLE: begin
                busy = 1'b0;
            end
            SCAN_RUN: begin
                busy    = 1'b1;
                tbl_we  = dynamic_ent;
                age_out = (tbl_rdata == STATE_LAST);
            end
        endcase
    end

endmodule

// File: rtl/mac_age_timer.sv
module mac_age_timer
    import age_pkg::*;
#(
    parameter int               N_ENTRIES    = 16,
    parameter int               COEFF_CYCLES = 50000,
    parameter logic [7:0]       AGE_RST      = 8'd1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ctl_wr,
    input  logic [15:0]                  ctl_wdata,
    input  logic                         age_wr,
    input  logic [7:0]                   age_wdata,
    output logic [15:0]                  ctl_rdata,
    output logic                         learn_all,
    output logic [3:0]                   db_hi,
    output logic                         age_tick,
    output logic                         scan_busy,
    output logic [$clog2(N_ENTRIES)-1:0] tbl_addr,
    input  logic [3:0]                   tbl_rdata,
    output logic                         tbl_we,
    output logic [3:0]                   tbl_wdata,
    output logic                         age_out,
    output logic [$clog2(N_ENTRIES)-1:0] age_out_idx
);

    localparam int IDX_W = $clog2(N_ENTRIES);

    logic [CTL_W-1:0] ctl_q;
    logic [AGE_W-1:0] age_val;
    logic             restart;

    age_ctl_reg #(.AGE_RST(AGE_RST)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .age_wr    (age_wr),
        .age_wdata (age_wdata),
        .ctl_q     (ctl_q),
        .age_val   (age_val),
        .restart   (restart)
    );

    age_prescaler #(.COEFF_CYCLES(COEFF_CYCLES)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .age_val (age_val),
        .tick    (age_tick)
    );

    age_scanner #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (age_tick),
        .tbl_addr    (tbl_addr),
        .tbl_rdata   (tbl_rdata),
        .tbl_we      (tbl_we),
        .tbl_wdata   (tbl_wdata),
        .busy        (scan_busy),
        .age_out     (age_out),
        .age_out_idx (age_out_idx)
    );

    assign ctl_rdata = ctl_q;
    assign learn_all = ctl_q[LEARN_BIT];
    assign db_hi     = ctl_q[CTL_W-1:DBH_LSB];

endmodule

// File: rtl/age_timer_chk.sv
module age_timer_chk #(
    parameter int N_ENTRIES    = 16,
    parameter int COEFF_CYCLES = 50000,
    parameter int IDX_W        = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             age_wr,
    input logic [7:0]       age_wdata,
    input logic [15:0]      ctl_rdata,
    input logic             age_tick,
    input logic             scan_busy,
    input logic [IDX_W-1:0] tbl_addr,
    input logic [3:0]       tbl_rdata,
    input logic             tbl_we,
    input logic [3:0]       tbl_wdata,
    input logic             age_out
);

    assert_age_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[11:4] != 8'd0);

    assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (COEFF_CYCLES > 1 && age_tick) |=> !age_tick);

    assert_restart_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (COEFF_CYCLES > 1 && age_wr && age_wdata != 8'd0) |=> !age_tick);

    assert_scan_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_busy) |-> (tbl_addr == '0));

    assert_addr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        scan_busy |-> (int'(tbl_addr) < N_ENTRIES));

    assert_skip_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> (scan_busy && tbl_rdata != 4'h0 && tbl_rdata != 4'hF));

    assert_free_on_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        age_out |-> (tbl_we && tbl_wdata == 4'h0));

endmodule

bind mac_age_timer age_timer_chk #(
    .N_ENTRIES    (N_ENTRIES),
    .COEFF_CYCLES (COEFF_CYCLES),
    .IDX_W        ($clog2(N_ENTRIES))
) u_age_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .age_wr    (age_wr),
    .age_wdata (age_wdata),
    .ctl_rdata (ctl_rdata),
    .age_tick  (age_tick),
    .scan_busy (scan_busy),
    .tbl_addr  (tbl_addr),
    .tbl_rdata (tbl_rdata),
    .tbl_we    (tbl_we),
    .tbl_wdata (tbl_wdata),
    .age_out   (age_out)
);

// File: tb/mac_age_timer_test.sv
`timescale 1ns/1ps
module mac_age_timer_test;

    localparam int N  = 8;
    localparam int C  = 4;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [15:0]   ctl_wdata = '0;
    logic          age_wr = 1'b0;
    logic [7:0]    age_wdata = '0;
    logic [15:0]   ctl_rdata;
    logic          learn_all;
    logic [3:0]    db_hi;
    logic          age_tick;
    logic          scan_busy;
    logic [IW-1:0] tbl_addr;
    logic [3:0]    tbl_rdata;
    logic          tbl_we;
    logic [3:0]    tbl_wdata;
    logic          age_out;
    logic [IW-1:0] age_out_idx;

    always #10 clk = ~clk;

    mac_age_timer #(.N_ENTRIES(N), .COEFF_CYCLES(C), .AGE_RST(8'd1)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .age_wr(age_wr), .age_wdata(age_wdata), .ctl_rdata(ctl_rdata),
        .learn_all(learn_all), .db_hi(db_hi), .age_tick(age_tick),
        .scan_busy(scan_busy), .tbl_addr(tbl_addr), .tbl_rdata(tbl_rdata),
        .tbl_we(tbl_we), .tbl_wdata(tbl_wdata), .age_out(age_out),
        .age_out_idx(age_out_idx)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // environment table memory and preload port
    logic          pl_en = 1'b0;
    logic [IW-1:0] pl_idx = '0;
    logic [3:0]    pl_val = '0;
    logic [3:0]    mem [N];

    assign tbl_rdata = mem[tbl_addr];

    always @(posedge clk) begin
        if (pl_en) mem[pl_idx] <= pl_val;
        else if (tbl_we) mem[tbl_addr] <= tbl_wdata;
    end

    // behavioural reference model
    logic [15:0] m_reg;
    int          m_cnt;
    bit          m_busy;
    int          m_idx;
    bit          m_pend;
    logic [3:0]  m_mem [N];

    always @(posedge clk) begin
        int  period;
        bit  tk;
        bit  legal;
        logic [3:0] s;
        if (pl_en) m_mem[pl_idx] = pl_val;
        if (!rst_n) begin
            m_reg = 16'h0010; m_cnt = 0; m_busy = 0; m_idx = 0; m_pend = 0;
        end else begin
            period = C * int'(m_reg[11:4]);
            tk = (m_cnt == period - 1);
            if (m_busy) begin
                s = m_mem[m_idx];
                if (s != 4'h0 && s != 4'hF) m_mem[m_idx] = s - 4'd1;
                if (m_idx == N - 1) begin
                    if (tk || m_pend) begin m_idx = 0; m_pend = 0; end
                    else m_busy = 0;
                end else begin
                    m_idx++;
                    if (tk) m_pend = 1;
                end
            end else if (tk) begin
                m_busy = 1; m_idx = 0; m_pend = 0;
            end
            legal = 0;
            if (ctl_wr) begin
                m_reg[15:12] = ctl_wdata[15:12];
                m_reg[3:0]   = ctl_wdata[3:0];
                if (ctl_wdata[11:4] != 0) begin m_reg[11:4] = ctl_wdata[11:4]; legal = 1; end
            end
            if (age_wr && age_wdata != 0) begin m_reg[11:4] = age_wdata; legal = 1; end
            if (legal) m_cnt = 0;
            else if (tk) m_cnt = 0;
            else m_cnt++;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        bit e_tick;
        logic [3:0] s;
        if (rst_n && !done) begin
            e_tick = (m_cnt == C * int'(m_reg[11:4]) - 1);
            chk(ctl_rdata == m_reg, "R1 R2 R3 R10 ctl_rdata", ctl_rdata, m_reg);
            chk(learn_all == m_reg[3], "R1 learn_all", learn_all, m_reg[3]);
            chk(db_hi == m_reg[15:12], "R1 db_hi", db_hi, m_reg[15:12]);
            chk(age_tick == e_tick, "R4 R5 age_tick", age_tick, e_tick);
            chk(scan_busy == m_busy, "R6 R9 scan_busy", scan_busy, m_busy);
            s = m_busy ? m_mem[m_idx] : 4'h0;
            if (m_busy) begin
                chk(int'(tbl_addr) == m_idx, "R6 R9 tbl_addr", tbl_addr, m_idx);
            end
            chk(tbl_we == (m_busy && s != 4'h0 && s != 4'hF), "R7 tbl_we", tbl_we,
                (m_busy && s != 4'h0 && s != 4'hF));
            if (tbl_we) chk(tbl_wdata == s - 4'd1, "R7 tbl_wdata", tbl_wdata, s - 4'd1);
            chk(age_out == (m_busy && s == 4'h1), "R8 age_out", age_out, (m_busy && s == 4'h1));
            if (age_out) chk(int'(age_out_idx) == m_idx, "R8 age_out_idx", age_out_idx, m_idx);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic preload(input logic [3:0] v [N]);
        for (int i = 0; i < N; i++) begin
            pl_en = 1'b1; pl_idx = IW'(i); pl_val = v[i];
            cyc(1);
        end
        pl_en = 1'b0;
    endtask

    task automatic wr_full(input logic [15:0] d);
        ctl_wr = 1'b1; ctl_wdata = d; cyc(1); ctl_wr = 1'b0;
    endtask

    task automatic wr_age(input logic [7:0] a);
        age_wr = 1'b1; age_wdata = a; cyc(1); age_wr = 1'b0;
    endtask

    task automatic table_final(input string tag);
        for (int i = 0; i < N; i++) begin
            chk(mem[i] == m_mem[i], tag, mem[i], m_mem[i]);
        end
    endtask

    logic [3:0] pat_a [N] = '{4'h1, 4'h2, 4'h3, 4'hF, 4'h0, 4'hE, 4'h1, 4'hF};
    logic [3:0] pat_b [N] = '{4'h2, 4'hF, 4'h2, 4'h0, 4'h3, 4'hF, 4'h1, 4'h2};

    initial begin
        cyc(1);
        preload(pat_a);
        @(negedge clk);
        chk(ctl_rdata == 16'h0010, "R1 reset value", ctl_rdata, 16'h0010);
        chk(scan_busy == 1'b0, "R6 reset idle", scan_busy, 0);
        chk(age_out == 1'b0, "R8 reset quiet", age_out, 0);
        cyc(1);
        rst_n = 1'b1;

        // age 1: period shorter than a pass, pending path active
        cyc(200);
        for (int i = 0; i < N; i++) begin
            chk(mem[i] == ((pat_a[i] == 4'hF) ? 4'hF : 4'h0), "R7 R8 R9 drained table",
                mem[i], (pat_a[i] == 4'hF) ? 4'hF : 4'h0);
        end
        table_final("R7 table image A");

        // register field behaviour
        wr_full(16'hB00A);
        cyc(1);
        chk(ctl_rdata == 16'hB01A, "R3 full write age 0", ctl_rdata, 16'hB01A);
        wr_age(8'd0);
        cyc(1);
        chk(ctl_rdata == 16'hB01A, "R3 age-only write 0", ctl_rdata, 16'hB01A);
        wr_age(8'd3);
        chk(ctl_rdata == 16'hB03A, "R2 age-only write", ctl_rdata, 16'hB03A);
        ctl_wr = 1'b1; ctl_wdata = 16'h5071; age_wr = 1'b1; age_wdata = 8'd9;
        cyc(1);
        ctl_wr = 1'b0; age_wr = 1'b0;
        chk(ctl_rdata == 16'h5091, "R10 simultaneous writes", ctl_rdata, 16'h5091);
        cyc(100);

        // second pattern, long period
        rst_n = 1'b0;
        preload(pat_b);
        rst_n = 1'b1;
        wr_age(8'd255);
        cyc(2200);
        table_final("R7 table image B");

        // repeated restarts hold off the tick
        for (int k = 0; k < 10; k++) begin
            wr_age(8'd2);
            cyc(5);
        end
        cyc(50);
        table_final("R5 table image C");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule